// File: doc/BRIEF.md
# Quadrature NCO Upconverter

This block moves a complex baseband signal onto a digital carrier. It takes I and Q sample streams that have already been pulse-shaped and interpolated to the master clock rate. It multiplies them by the cosine and sine of a numerically controlled oscillator (NCO) phase, sums the two products and saturates the result to a single real sample for a DAC. The carrier phase comes from a 24-bit accumulator that advances by a tuning increment on every clock, so the frequency step is the master clock divided by 2^24. The highest carrier worth programming is roughly 40% of the master clock.

Three tuning words are held in a small write-only register bank. A selector input names the word to use. The accumulator picks up that word only when a load strobe is pulsed, so a retune never applies a half-written value. Two mix controls change the output. The spectrum-invert control negates the cosine term, which swaps the upper and lower sidebands. The sine-freeze control removes the sine term, which collapses the constellation onto the I axis. Sine and cosine come from one quarter-wave magnitude table that is computed at elaboration and unfolded by quadrant.

Top module: `nco_upmix`

## Requirements
- R1: After reset, out_valid and out_sample are 0, the three tuning words and the active increment are 0, and the accumulator is 0. With no load, the output therefore stays at I·cos(0), which is the I sample scaled by 511/512.
- R2: A write with cfg_we high stores cfg_data into word A, B or C for cfg_addr 0, 1 or 2 respectively.
- R3: A write by itself does not change the active increment. On a clock where load_stb is high, the active increment becomes the word that word_sel names (0 = A, 1 = B, 2 = C). While load_stb is low, the increment holds.
- R4: The accumulator adds the active increment on every clock. The table phase is the top 10 accumulator bits. Phase 0 gives cos = +511 and sin = 0; phase 256 gives sin = +511 and cos = 0; phase 512 gives cos = −511; phase 768 gives sin = −511.
- R5: In normal mode, out_sample = (I·cos + Q·sin) shifted right arithmetically by 9 bits (rounded toward minus infinity), all as 10-bit signed values.
- R6: When spec_inv is high, out_sample = (−I·cos + Q·sin) shifted right arithmetically by 9 bits.
- R7: When sin_freeze is high, the sine term is zero, so out_sample = (±I·cos) shifted right arithmetically by 9 bits.
- R8: out_valid equals in_valid from two clocks earlier. out_sample at that clock is built from the I, Q and control inputs present at the same earlier edge, and from the phase the accumulator held just before that edge.
- R9: The shifted sum saturates to the 10-bit signed range: above +511 gives +511 and below −512 gives −512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Tuning word write enable |
| cfg_addr | input | 2 | Tuning word index for a write (0 = A, 1 = B, 2 = C) |
| cfg_data | input | 24 | Tuning word write data |
| load_stb | input | 1 | Copies the selected word into the active increment |
| word_sel | input | 2 | Tuning word chosen at a load |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 10 | In-phase baseband sample, signed |
| in_q | input | 10 | Quadrature baseband sample, signed |
| spec_inv | input | 1 | Negates the cosine term |
| sin_freeze | input | 1 | Forces the sine term to zero |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 10 | Mixed, saturated real sample, signed |

## Verification
Every mixed result appears two rising edges after its inputs are driven: one edge for the input and phase register, one for the product and sum register. A load strobe changes the increment one edge later, and the accumulator moves on the edge after that. The bench drives on falling edges and samples on falling edges. For the latency case it checks the output one edge after the stimulus (unchanged) and two edges after it (new value). For a rotating carrier it uses increments of a quarter or a half turn, lets the pipeline settle, then compares four consecutive samples against the expected cardinal-phase values in any cyclic rotation. That check does not depend on where the carrier was when the load landed.

// File: rtl/nco_upmix_pkg.sv
package nco_upmix_pkg;

   // Integer sine approximation (rational form) for one quarter wave:
   // index k of n steps spans 0..90 degrees, result scaled to amp.
   // Exact at k = 0 (zero) and k = n (amp). Used only at elaboration.
   function automatic int quarter_mag(int k, int n, int amp);
      longint p;
      longint nn;
      longint span;
      longint num;
      longint den;
      p    = longint'(k);
      nn   = longint'(n);
      span = p * (2 * nn - p);
      num  = longint'(amp) * 16 * span;
      den  = 20 * nn * nn - 4 * span;
      return int'((num + den / 2) / den);
   endfunction

endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank #(
   parameter int NUM_WORDS = 3,
   parameter int PHASE_W   = 24,
   parameter int SEL_W     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [SEL_W-1:0]   addr_i,
   input  logic [PHASE_W-1:0] wdata_i,
   input  logic               load_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic [PHASE_W-1:0] inc_o
);

   if (NUM_WORDS < 1 || (1 << SEL_W) < NUM_WORDS) begin : g_bad_sel
      $error("nco_word_bank: SEL_W too narrow for NUM_WORDS");
   end

   logic [PHASE_W-1:0] words [NUM_WORDS];
   logic [PHASE_W-1:0] pick;
   logic               hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WORDS; w++) words[w] <= '0;
      end else if (we_i) begin
         for (int w = 0; w < NUM_WORDS; w++)
            if (addr_i == SEL_W'(w)) words[w] <= wdata_i;
      end
   end

   always_comb begin
      pick = '0;
      hit  = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (sel_i == SEL_W'(w)) begin
            pick = words[w];
            hit  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            inc_o <= '0;
      else if (load_i && hit) inc_o <= pick;
   end

   // R3: the increment only moves on a load
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(inc_o));

   // R3: a load of word A takes the stored bank value
   p_load_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && sel_i == '0) |=> (inc_o == $past(words[0])));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 24,
   parameter int LUT_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] inc_i,
   output logic [LUT_W-1:0]   phase_o
);

   if (LUT_W > PHASE_W) begin : g_bad_w
      $error("nco_phase_acc: LUT_W exceeds PHASE_W");
   end

   logic [PHASE_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc + inc_i;
   end

   assign phase_o = acc[PHASE_W-1 -: LUT_W];

   // R4: a zero increment parks the phase
   p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i == '0) |=> $stable(phase_o));

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut
   import nco_upmix_pkg::*;
#(
   parameter int LUT_W = 10,
   parameter int AMP_W = 10
) (
   input  logic [LUT_W-1:0]        phase_i,
   output logic signed [AMP_W-1:0] cos_o,
   output logic signed [AMP_W-1:0] sin_o
);

   localparam int QW      = LUT_W - 2;
   localparam int N       = 1 << QW;
   localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
   localparam logic [QW:0] NV = (QW + 1)'(N);

   if (LUT_W < 3 || AMP_W < 3) begin : g_bad_w
      $error("nco_quarter_lut: widths too small");
   end

   logic [AMP_W-2:0] tbl [0:N];

   for (genvar k = 0; k <= N; k++) begin : g_tbl
      localparam int MAG = quarter_mag(k, N, AMP_MAX);
      assign tbl[k] = (AMP_W - 1)'(MAG);
   end

   logic [1:0]              quad;
   logic [QW:0]             fwd_idx;
   logic [QW:0]             rev_idx;
   logic signed [AMP_W-1:0] fwd;
   logic signed [AMP_W-1:0] rev;

   assign quad    = phase_i[LUT_W-1 -: 2];
   assign fwd_idx = {1'b0, phase_i[QW-1:0]};
   assign rev_idx = NV - fwd_idx;
   assign fwd     = signed'({1'b0, tbl[fwd_idx]});
   assign rev     = signed'({1'b0, tbl[rev_idx]});

   always_comb begin
      case (quad)
         2'd0:    begin sin_o = fwd;  cos_o = rev;  end
         2'd1:    begin sin_o = rev;  cos_o = -fwd; end
         2'd2:    begin sin_o = -fwd; cos_o = -rev; end
         default: begin sin_o = -rev; cos_o = fwd;  end
      endcase
   end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
   parameter int SAMP_W = 10,
   parameter int AMP_W  = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid_i,
   input  logic signed [SAMP_W-1:0] i_i,
   input  logic signed [SAMP_W-1:0] q_i,
   input  logic signed [AMP_W-1:0]  cos_i,
   input  logic signed [AMP_W-1:0]  sin_i,
   input  logic                     inv_i,
   input  logic                     freeze_i,
   output logic                     valid_o,
   output logic signed [SAMP_W-1:0] sample_o
);

   localparam int PW    = SAMP_W + AMP_W;
   localparam int SUMW  = PW + 1;
   localparam int SHIFT = AMP_W - 1;
   localparam logic signed [SUMW-1:0] MAXV = SUMW'((1 << (SAMP_W - 1)) - 1);
   localparam logic signed [SUMW-1:0] MINV = -MAXV - SUMW'(1);

   // stage 1: inputs and carrier captured together
   logic                     s1_valid;
   logic signed [SAMP_W-1:0] s1_i;
   logic signed [SAMP_W-1:0] s1_q;
   logic signed [AMP_W-1:0]  s1_cos;
   logic signed [AMP_W-1:0]  s1_sin;
   logic                     s1_inv;
   logic                     s1_freeze;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_i      <= '0;
         s1_q      <= '0;
         s1_cos    <= '0;
         s1_sin    <= '0;
         s1_inv    <= 1'b0;
         s1_freeze <= 1'b0;
      end else begin
         s1_valid  <= valid_i;
         s1_i      <= i_i;
         s1_q      <= q_i;
         s1_cos    <= cos_i;
         s1_sin    <= sin_i;
         s1_inv    <= inv_i;
         s1_freeze <= freeze_i;
      end
   end

   // stage 2: products, sum, scale, clamp
   logic signed [AMP_W-1:0] sin_eff;
   logic signed [PW-1:0]    prod_i;
   logic signed [PW-1:0]    prod_q;
   logic signed [PW-1:0]    term_i;
   logic signed [SUMW-1:0]  sum;
   logic signed [SUMW-1:0]  scaled;
   logic signed [SAMP_W-1:0] clamped;

   assign sin_eff = s1_freeze ? '0 : s1_sin;
   assign prod_i  = s1_i * s1_cos;
   assign prod_q  = s1_q * sin_eff;
   assign term_i  = s1_inv ? -prod_i : prod_i;
   assign sum     = SUMW'(term_i) + SUMW'(prod_q);
   assign scaled  = sum >>> SHIFT;

   always_comb begin
      if (scaled > MAXV)      clamped = MAXV[SAMP_W-1:0];
      else if (scaled < MINV) clamped = MINV[SAMP_W-1:0];
      else                    clamped = scaled[SAMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         sample_o <= '0;
      end else begin
         valid_o  <= s1_valid;
         sample_o <= clamped;
      end
   end

   // R5: zero I with zero sine gives a zero sample
   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_i == '0 && s1_sin == '0) |=> (sample_o == '0));

   // R7: frozen sine and zero I leave nothing to mix
   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_freeze && s1_i == '0) |=> (sample_o == '0));

   // R6: inverted positive cosine term alone must go negative
   p_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_inv && s1_q == '0 && s1_i > 0 && s1_cos > 0) |=> (sample_o < 0));

endmodule

// File: rtl/nco_upmix.sv
module nco_upmix #(
   parameter int PHASE_W   = 24,
   parameter int NUM_WORDS = 3,
   parameter int LUT_W     = 10,
   parameter int AMP_W     = 10,
   parameter int SAMP_W    = 10,
   parameter int SEL_W     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_addr,
   input  logic [PHASE_W-1:0] cfg_data,
   input  logic               load_stb,
   input  logic [SEL_W-1:0]   word_sel,
   input  logic               in_valid,
   input  logic [SAMP_W-1:0]  in_i,
   input  logic [SAMP_W-1:0]  in_q,
   input  logic               spec_inv,
   input  logic               sin_freeze,
   output logic               out_valid,
   output logic [SAMP_W-1:0]  out_sample
);

   localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
   localparam logic [LUT_W-1:0] QUARTER = LUT_W'(1 << (LUT_W - 2));

   logic [PHASE_W-1:0]       inc;
   logic [LUT_W-1:0]         phase;
   logic signed [AMP_W-1:0]  cos_v;
   logic signed [AMP_W-1:0]  sin_v;
   logic signed [SAMP_W-1:0] mix_out;

   nco_word_bank #(
      .NUM_WORDS (NUM_WORDS),
      .PHASE_W   (PHASE_W),
      .SEL_W     (SEL_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .addr_i  (cfg_addr),
      .wdata_i (cfg_data),
      .load_i  (load_stb),
      .sel_i   (word_sel),
      .inc_o   (inc)
   );

   nco_phase_acc #(
      .PHASE_W (PHASE_W),
      .LUT_W   (LUT_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc),
      .phase_o (phase)
   );

   nco_quarter_lut #(
      .LUT_W (LUT_W),
      .AMP_W (AMP_W)
   ) u_lut (
      .phase_i (phase),
      .cos_o   (cos_v),
      .sin_o   (sin_v)
   );

   // R4: cardinal table points
   p_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == '0) |-> (cos_v == AMP_W'(AMP_MAX) && sin_v == '0));
   p_quarter_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == QUARTER) |-> (sin_v == AMP_W'(AMP_MAX) && cos_v == '0));

   nco_mixer #(
      .SAMP_W (SAMP_W),
      .AMP_W  (AMP_W)
   ) u_mix (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (in_valid),
      .i_i      (signed'(in_i)),
      .q_i      (signed'(in_q)),
      .cos_i    (cos_v),
      .sin_i    (sin_v),
      .inv_i    (spec_inv),
      .freeze_i (sin_freeze),
      .valid_o  (out_valid),
      .sample_o (mix_out)
   );

   assign out_sample = unsigned'(mix_out);

   // R8: output strobe follows the input strobe two clocks later
   p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/test_nco_upmix.sv
module test_nco_upmix;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_addr;
   logic [23:0] cfg_data;
   logic        load_stb;
   logic [1:0]  word_sel;
   logic        in_valid;
   logic [9:0]  in_i;
   logic [9:0]  in_q;
   logic        spec_inv;
   logic        sin_freeze;
   logic        out_valid;
   logic [9:0]  out_sample;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   nco_upmix i_nco_upmix (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_data   (cfg_data),
      .load_stb   (load_stb),
      .word_sel   (word_sel),
      .in_valid   (in_valid),
      .in_i       (in_i),
      .in_q       (in_q),
      .spec_inv   (spec_inv),
      .sin_freeze (sin_freeze),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   localparam int QTR  = 24'h400000;
   localparam int HALF = 24'h800000;
   localparam int OCT  = 24'h200000;

   function automatic int outv();
      return int'($signed(out_sample));
   endfunction

   function automatic int mix(int i, int q, int c, int s, bit inv);
      int t;
      t = (inv ? -(i * c) : i * c) + q * s;
      t = t >>> 9;
      if (t > 511) t = 511;
      if (t < -512) t = -512;
      return t;
   endfunction

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rot(string req, int e0, int e1, int e2, int e3);
      int s [4];
      int e [4];
      bit ok;
      e = '{e0, e1, e2, e3};
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         s[k] = outv();
      end
      ok = 1'b0;
      for (int r = 0; r < 4; r++) begin
         bit m;
         m = 1'b1;
         for (int k = 0; k < 4; k++) if (s[k] != e[(k + r) % 4]) m = 1'b0;
         if (m) ok = 1'b1;
      end
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d,%0d,%0d,%0d expected rotation of %0d,%0d,%0d,%0d",
                  req, s[0], s[1], s[2], s[3], e0, e1, e2, e3);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
      load_stb = 1'b0; word_sel = '0; in_valid = 1'b0; in_i = '0; in_q = '0;
      spec_inv = 1'b0; sin_freeze = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_data = 24'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ld(int sel);
      @(negedge clk);
      load_stb = 1'b1; word_sel = 2'(sel);
      @(negedge clk);
      load_stb = 1'b0;
   endtask

   task automatic drive(int i, int q);
      @(negedge clk);
      in_valid = 1'b1; in_i = 10'(i); in_q = 10'(q);
      repeat (3) @(negedge clk);
   endtask

   // R1: reset state and zero tuning words
   task automatic t_reset_state();
      do_reset();
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      chk("R1 out_sample after reset", outv(), 0);
      drive(200, -100);
      chk_rot("R1 steady at phase 0", 199, 199, 199, 199);
   endtask

   // R2 R3: write without load has no effect, load applies it
   task automatic t_write_then_load();
      do_reset();
      wr(0, QTR);
      drive(200, -100);
      chk_rot("R3 write without load", 199, 199, 199, 199);
      ld(0);
      repeat (2) @(negedge clk);
      chk_rot("R2 R4 R5 quarter-turn rotation", 199, -100, -200, 99);
   endtask

   // R8: two-clock latency on strobe and data
   task automatic t_latency();
      do_reset();
      repeat (3) @(negedge clk);
      in_valid = 1'b1; in_i = 10'(100); in_q = 10'(50);
      @(negedge clk);
      chk("R8 valid not yet after one edge", int'(out_valid), 0);
      chk("R8 sample not yet after one edge", outv(), 0);
      in_valid = 1'b0; in_i = 10'(-300);
      @(negedge clk);
      chk("R8 valid after two edges", int'(out_valid), 1);
      chk("R8 sample after two edges", outv(), mix(100, 50, 511, 0, 0));
      @(negedge clk);
      chk("R8 valid drops two edges later", int'(out_valid), 0);
      chk("R8 next sample", outv(), mix(-300, 50, 511, 0, 0));
   endtask

   // R6: spectrum inversion
   task automatic t_invert();
      do_reset();
      spec_inv = 1'b1;
      drive(200, -100);
      chk("R6 inverted at phase 0", outv(), mix(200, -100, 511, 0, 1));
      wr(1, QTR);
      ld(1);
      repeat (2) @(negedge clk);
      chk_rot("R6 inverted rotation", -200, -100, 199, 99);
   endtask

   // R7: sine freeze
   task automatic t_freeze();
      do_reset();
      sin_freeze = 1'b1;
      wr(2, QTR);
      ld(2);
      drive(200, -100);
      chk_rot("R7 frozen sine rotation", 199, 0, -200, 0);
      spec_inv = 1'b1;
      repeat (3) @(negedge clk);
      chk_rot("R7 R6 frozen and inverted", -200, 0, 199, 0);
   endtask

   // R2 R3: switching between the three words
   task automatic t_word_select();
      int s0;
      do_reset();
      wr(1, QTR);
      wr(2, HALF);
      drive(200, -100);
      ld(2);
      repeat (2) @(negedge clk);
      chk_rot("R3 word C half-turn", 199, -200, 199, -200);
      ld(1);
      repeat (2) @(negedge clk);
      chk_rot("R3 word B quarter-turn", 199, -100, -200, 99);
      ld(0);
      repeat (3) @(negedge clk);
      s0 = outv();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R3 word A parks carrier", outv(), s0);
      end
   endtask

   // R9 R5: saturation at 45 degrees
   task automatic t_saturate();
      do_reset();
      wr(0, OCT);
      @(negedge clk);
      load_stb = 1'b1; word_sel = 2'd0;
      @(negedge clk);
      word_sel = 2'd1;
      @(negedge clk);
      load_stb = 1'b0;
      drive(100, -100);
      chk("R5 equal cos and sin cancel", outv(), 0);
      drive(511, 511);
      chk("R9 positive clamp", outv(), 511);
      drive(-512, -512);
      chk("R9 negative clamp", outv(), -512);
      spec_inv = 1'b1;
      drive(-512, 511);
      chk("R9 R6 inverted clamp", outv(), 511);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      t_reset_state();
      t_write_then_load();
      t_latency();
      t_invert();
      t_freeze();
      t_word_select();
      t_saturate();
      report();
      $finish;
   end

endmodule